// File: doc/BRIEF.md
# Selectable-Ratio Bus Clock Divider

This block takes the fast core clock and produces a slower system bus clock from it. It also produces a strobe, in the core domain, that marks each bus clock rising edge. The division ratio is 2, 3 or 4. Two strap inputs choose the ratio. The block captures them while reset is held and ignores them once reset is released.

The bus clock leaves the block as a flip-flop output, so its waveform is free of decode glitches. In the 2:1 and 4:1 settings the bus clock has a 50% duty cycle. In the 3:1 setting it is high for one core cycle in three, so its duty cycle is about 33%; downstream users must respect that short high phase.

The rise strobe is high for exactly one core cycle, in the cycle where the bus clock goes from low to high. Core-domain logic uses it as a clock enable to move data to or from the bus domain on bus edges.

Top module: `busclk_divider`

## Requirements
- R1: While `rst_n` is low, both `bus_clk` and `bus_rise` are 0 one core edge after the reset is sampled.
- R2: With strap bit 1 equal to 0 (`ratio_sel` = 2'b00 or 2'b01), the bus clock period is 2 core cycles: high 1, low 1.
- R3: With `ratio_sel` = 2'b11, the bus clock period is 3 core cycles: high 1, low 2.
- R4: With `ratio_sel` = 2'b10, the bus clock period is 4 core cycles: high 2, low 2.
- R5: `bus_rise` is 1 for exactly one core cycle per bus period. That is the cycle in which `bus_clk` changes from 0 to 1, and `bus_rise` is 0 in every other cycle.
- R6: A change on `ratio_sel` after `rst_n` has gone high has no effect on the ratio or on the phase of the outputs.
- R7: On the first core rising edge after `rst_n` goes high, `bus_clk` and `bus_rise` both become 1. The internal phase count starts from 0, and the bus clock is high for phase counts below half the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| core_clk | input | 1 | Fast core clock; every register in the block uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the ratio straps are captured while it is low |
| ratio_sel | input | 2 | Ratio straps: bit 1 = 0 gives 2:1, 2'b11 gives 3:1, 2'b10 gives 4:1 |
| bus_clk | output | 1 | Registered divided bus clock |
| bus_rise | output | 1 | One-core-cycle strobe in the cycle where bus_clk rises |

## Verification
All four strap codes are swept, and for each one both outputs are compared every core cycle with a waveform that the bench computes arithmetically from the cycle count since reset release.

- Running both 2'b00 and 2'b01 shows that strap bit 0 is a don't-care at 2:1.
- Running 2'b11 against 2'b10 separates the asymmetric 3:1 waveform from the 50% 4:1 waveform.

Partway through each run the straps are inverted while reset is high. The unchanged waveform after that point shows that the captured ratio, and not the live input, controls the divider. Checking the first cycle after release pins down the starting phase.

// File: rtl/busclk_pkg.sv
// Package: shared types and helpers for the bus clock divider.
// Assumes a two-bit strap field and ratios of at most four.
package busclk_pkg;

    localparam int SEL_W   = 2;
    localparam int MAX_DIV = 4;
    localparam int CNT_W   = $clog2(MAX_DIV);
    localparam int DIV_W   = CNT_W + 1;

    typedef enum logic [1:0] {
        RATIO_2 = 2'd0,
        RATIO_3 = 2'd1,
        RATIO_4 = 2'd2
    } ratio_e;

    // Map strap bits to a ratio; bit 0 is ignored when bit 1 is low.
    function automatic ratio_e decode_straps(input logic [SEL_W-1:0] sel);
        if (!sel[1])
            return RATIO_2;
        else if (sel[0])
            return RATIO_3;
        else
            return RATIO_4;
    endfunction

    // Number of core cycles in one bus period for a ratio.
    function automatic logic [DIV_W-1:0] ratio_cycles(input ratio_e r);
        case (r)
            RATIO_3: return DIV_W'(3);
            RATIO_4: return DIV_W'(4);
            default: return DIV_W'(2);
        endcase
    endfunction

endpackage

// File: rtl/ratio_strap_latch.sv
// Module: ratio_strap_latch
// Captures the strap inputs on every core edge while reset is low.
// Holds the captured ratio once reset is released.
// Assumes the straps are stable on the last edge before reset release.
module ratio_strap_latch
    import busclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] straps,
    output ratio_e           ratio
);

    ratio_e ratio_q;

    // Purpose: follow the straps during reset, freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= decode_straps(straps);
    end

    assign ratio = ratio_q;

endmodule

// File: rtl/phase_counter.sv
// Module: phase_counter
// Counts core cycles from 0 up to period-1, then wraps to 0.
// Cleared by synchronous reset.
// Assumes the period is at least 2 and at most 2**CNT_W.
module phase_counter #(
    parameter int CNT_W = 2,
    parameter int DIV_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period,
    output logic [CNT_W-1:0] phase
);

    logic [CNT_W-1:0] last_phase;
    logic [DIV_W-1:0] period_m1;

    // Purpose: index of the final phase in one bus period.
    always_comb begin
        period_m1  = period - DIV_W'(1);
        last_phase = period_m1[CNT_W-1:0];
    end

    // Purpose: advance the phase, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == last_phase)
            phase <= '0;
        else
            phase <= phase + CNT_W'(1);
    end

endmodule

// File: rtl/wave_shaper.sv
// Module: wave_shaper
// Turns the phase count into registered bus clock and rise strobe outputs.
// The clock is high for phases below period/2.
// The strobe is high for phase 0.
// Both outputs lag the phase by one register stage.
module wave_shaper #(
    parameter int CNT_W = 2,
    parameter int DIV_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    output logic             clk_out,
    output logic             rise_out
);

    logic [DIV_W-1:0] high_len;
    logic             high_next;
    logic             rise_next;

    // Purpose: decode the next output levels from the current phase.
    always_comb begin
        high_len  = period >> 1;
        high_next = ({1'b0, phase} < high_len);
        rise_next = (phase == '0);
    end

    // Purpose: register the outputs so they are free of decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_out  <= 1'b0;
            rise_out <= 1'b0;
        end else begin
            clk_out  <= high_next;
            rise_out <= rise_next;
        end
    end

endmodule

// File: rtl/busclk_divider.sv
// Module: busclk_divider (top)
// Divides the core clock by 2, 3 or 4, as chosen by straps captured during reset.
// Drives a registered bus clock and a core-domain rise strobe.
// Assumes a synchronous active-low reset and straps that are static after reset.
module busclk_divider
    import busclk_pkg::*;
(
    input  logic             core_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             bus_clk,
    output logic             bus_rise
);

    ratio_e           ratio_held;
    logic [DIV_W-1:0] period;
    logic [CNT_W-1:0] phase;

    ratio_strap_latch u_straps (
        .clk    (core_clk),
        .rst_n  (rst_n),
        .straps (ratio_sel),
        .ratio  (ratio_held)
    );

    // Purpose: turn the held ratio into a cycle count.
    always_comb period = ratio_cycles(ratio_held);

    phase_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_phase (
        .clk    (core_clk),
        .rst_n  (rst_n),
        .period (period),
        .phase  (phase)
    );

    wave_shaper #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_wave (
        .clk      (core_clk),
        .rst_n    (rst_n),
        .period   (period),
        .phase    (phase),
        .clk_out  (bus_clk),
        .rise_out (bus_rise)
    );

endmodule

// File: rtl/busclk_divider_checker.sv
// Module: busclk_divider_checker
// Temporal checks on the divider's ports and held ratio.
// Attached to the top through a bind statement.
module busclk_divider_checker
    import busclk_pkg::*;
(
    input logic   core_clk,
    input logic   rst_n,
    input logic   bus_clk,
    input logic   bus_rise,
    input ratio_e ratio_held
);

    logic reset_seen;

    // Purpose: note that reset was sampled on the previous edge.
    always_ff @(posedge core_clk) reset_seen <= !rst_n;

    // Purpose: outputs must be low one edge after reset is sampled.
    always_ff @(posedge core_clk) begin
        if (reset_seen)
            assert_reset_quiet_R1: assert (!bus_clk && !bus_rise);
    end

    assert_div2_toggle_R2: assert property (@(posedge core_clk) disable iff (!rst_n)
        (ratio_held == RATIO_2 && bus_clk) |=> !bus_clk);

    assert_div3_short_high_R3: assert property (@(posedge core_clk) disable iff (!rst_n)
        (ratio_held == RATIO_3 && bus_clk) |=> !bus_clk);

    assert_div4_two_high_R4: assert property (@(posedge core_clk) disable iff (!rst_n)
        (ratio_held == RATIO_4 && $rose(bus_clk)) |=> bus_clk);

    assert_rise_marks_edge_R5: assert property (@(posedge core_clk) disable iff (!rst_n)
        $rose(bus_clk) |-> bus_rise);

    assert_rise_has_clock_R5: assert property (@(posedge core_clk) disable iff (!rst_n)
        bus_rise |-> bus_clk);

    assert_rise_single_R5: assert property (@(posedge core_clk) disable iff (!rst_n)
        bus_rise |=> !bus_rise);

    assert_ratio_frozen_R6: assert property (@(posedge core_clk) disable iff (!rst_n)
        rst_n |=> $stable(ratio_held));

endmodule

bind busclk_divider busclk_divider_checker u_checker (
    .core_clk   (core_clk),
    .rst_n      (rst_n),
    .bus_clk    (bus_clk),
    .bus_rise   (bus_rise),
    .ratio_held (ratio_held)
);

// File: tb/busclk_divider_test.sv
// Bench: sweeps every strap code.
// Compares both outputs every core cycle with values derived from the cycle count.
module busclk_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 24;
    localparam int FLIP_AT    = 8;
    localparam int WATCHDOG   = 5000;

    logic       core_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       bus_clk;
    logic       bus_rise;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    busclk_divider uut (
        .core_clk  (core_clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .bus_clk   (bus_clk),
        .bus_rise  (bus_rise)
    );

    always #(CLK_PERIOD/2) core_clk = ~core_clk;

    task automatic check(input string req, input logic act, input logic exp, input int cyc);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // Ratio from the strap code: bit1=0 -> 2, 2'b11 -> 3, 2'b10 -> 4.
    function automatic int ratio_of(input logic [1:0] s);
        if (!s[1]) return 2;
        return s[0] ? 3 : 4;
    endfunction

    task automatic run_code(input logic [1:0] code);
        int n;
        int ph;
        string req;
        n = ratio_of(code);
        req = (n == 2) ? "R2" : (n == 3) ? "R3" : "R4";
        @(negedge core_clk);
        rst_n = 1'b0;
        ratio_sel = code;
        repeat (3) @(negedge core_clk);
        check("R1 clk in reset", bus_clk, 1'b0, 0);
        check("R1 rise in reset", bus_rise, 1'b0, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= RUN_CYCLES; k++) begin
            @(negedge core_clk);
            ph = (k - 1) % n;
            if (k == 1) begin
                check("R7 first clk", bus_clk, 1'b1, k);
                check("R7 first rise", bus_rise, 1'b1, k);
            end
            if (k > FLIP_AT) begin
                check("R6 clk after strap change", bus_clk, (ph < n / 2), k);
                check("R6 rise after strap change", bus_rise, (ph == 0), k);
            end else begin
                check(req, bus_clk, (ph < n / 2), k);
                check("R5", bus_rise, (ph == 0), k);
            end
            if (k == FLIP_AT) ratio_sel = ~code;
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) run_code(2'(c));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge core_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule